// File: doc/BRIEF.md
# Processor exception entry controller

This block is the commit logic for taking a synchronous exception, an interrupt or a soft reset in a 32-bit processor with a system-control register file. Each cycle it looks at three request inputs: a reset request, an exception request with a 5-bit cause code and a TLB-refill flag, and an interrupt request. It also sees the current PC, a branch-delay-slot flag, the faulting address, the address-space ID, a coprocessor ID and the present Status, Cause, shadow-set control and exception-base values. At most one request is accepted, chosen by a fixed priority.

On the clock edge that accepts a request, the block registers a complete write-back bundle for the control register file. The bundle holds new Status, Cause, shadow-set control, EPC, BadVAddr, EntryHi and Context page-number values, a write strobe for each, and the new fetch address with a one-cycle redirect pulse. The register file applies the bundle on the next edge, and the fetch unit follows the redirect.

Field positions: Status EXL = bit 1, BEV = bit 22, CU1 = bit 29. Cause ExcCode = [6:2], CE = [29:28], IV = bit 23, BD = bit 31. Shadow-set control: current set [3:0], previous set [9:6], exception set [15:12]. The exception base is ebase[31:12] with the low 12 bits taken as zero. EntryHi: page pair number [31:13], ASID [7:0], bits [12:8] written as zero.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An accepted exception writes its 5-bit request code into Cause[6:2]. An accepted interrupt writes code 0 there. All Cause bits outside [6:2], [29:28] and 31 keep their input values.
- R2: For an accepted exception or interrupt, the EPC output is PC-4 and Cause[31] is 1 when the delay-slot flag is set. Otherwise the EPC output is PC and Cause[31] is 0.
- R3: Every accepted exception or interrupt writes Status with bit 1 (EXL) set and all other bits unchanged, whatever the previous EXL value.
- R4: The shadow-set control register is written only when both Status bits 1 and 22 are 0 at acceptance. The written value has [9:6] set to the old [3:0], [3:0] set to the old [15:12], and all other bits kept. Otherwise its strobe stays 0.
- R5: A general exception redirects to exception base + 0x180.
- R6: An exception with the refill flag and code 2 or 3 redirects to exception base + 0x000 when Status bit 1 was 0 at acceptance, and to base + 0x180 when it was 1.
- R7: Code 12 (arithmetic overflow) with Status bit 22 = 1 redirects to 0xBFC00200. With bit 22 = 0 it uses base + 0x180.
- R8: An interrupt redirects to base + 0x200 when Cause bit 23 is 1, and to base + 0x180 when it is 0.
- R9: Cause[29:28] is written as 0 on every exception and interrupt, except code 11 (coprocessor unusable), where it takes the 2-bit coprocessor ID.
- R10: BadVAddr is written with the faulting address for codes 1 to 5 only. Its strobe is 0 for every other code and for interrupts.
- R11: For codes 1, 2 and 3 only, EntryHi is written with address[31:13] in [31:13] and the ASID in [7:0], and the Context page field is written with address[31:13].
- R12: A reset request redirects to 0xBFC00000 and writes Status with bit 29 set and other bits kept. No other register strobe is raised. After power-on reset the fetch address output is 0xBFC00000 and all strobes are 0.
- R13: Priority is reset request, then exception, then interrupt. The bundle and redirect appear after the accepting edge and last one cycle. With no request, all strobes and the redirect are 0 and the fetch address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Soft reset request |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 5 | Exception cause code |
| tlb_refill_i | input | 1 | Exception is a TLB refill |
| intr_req_i | input | 1 | Interrupt request |
| pc_i | input | 32 | PC of the affected instruction |
| dslot_i | input | 1 | Instruction is in a branch delay slot |
| bad_addr_i | input | 32 | Faulting virtual address |
| asid_i | input | 8 | Current address-space ID |
| cop_id_i | input | 2 | Offending coprocessor number |
| status_i | input | 32 | Current Status |
| cause_i | input | 32 | Current Cause |
| srsctl_i | input | 32 | Current shadow-set control |
| ebase_i | input | 32 | Exception base |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| fetch_pc_o | output | 32 | New fetch address (held) |
| status_we_o | output | 1 | Status write strobe |
| status_o | output | 32 | New Status |
| cause_we_o | output | 1 | Cause write strobe |
| cause_o | output | 32 | New Cause |
| srs_we_o | output | 1 | Shadow-set control write strobe |
| srsctl_o | output | 32 | New shadow-set control |
| epc_we_o | output | 1 | EPC write strobe |
| epc_o | output | 32 | New EPC |
| badva_we_o | output | 1 | BadVAddr write strobe |
| badva_o | output | 32 | New BadVAddr |
| mmu_we_o | output | 1 | EntryHi and Context strobe |
| entryhi_o | output | 32 | New EntryHi |
| ctx_vpn_o | output | 19 | New Context page field |

## Verification
Two pairs of functions can fall in one cycle. The first pair is a reset request with an exception. The second is an exception with an interrupt. Each pair is provoked by raising both request inputs before the same edge. The bench then judges the winner by its unique traces. For a reset these are the 0xBFC00000 target, Status bit 29 and lowered EPC and Cause strobes. For an exception they are its own ExcCode and BadVAddr strobe, not code 0 or the interrupt vector. Vector selection is also tested on both sides of each state bit (EXL for refills, BEV for overflow, IV for interrupts).

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int DATA_W   = 32;
  localparam int ASID_W   = 8;
  localparam int CODE_W   = 5;
  localparam int COP_W    = 2;
  localparam int SET_W    = 4;
  localparam int VPN_LSB  = 13;
  localparam int VPN_W    = DATA_W - VPN_LSB;
  localparam int BASE_LSB = 12;

  // Status fields
  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;
  // Cause fields
  localparam int CA_CODE_LO = 2;
  localparam int CA_IV      = 23;
  localparam int CA_CE_LO   = 28;
  localparam int CA_BD      = 31;
  // Shadow-set control fields
  localparam int SS_CUR_LO  = 0;
  localparam int SS_PREV_LO = 6;
  localparam int SS_EXC_LO  = 12;

  localparam logic [CODE_W-1:0] EC_IRQ    = 5'd0;
  localparam logic [CODE_W-1:0] EC_TLBMOD = 5'd1;
  localparam logic [CODE_W-1:0] EC_TLBLD  = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLBST  = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADST   = 5'd5;
  localparam logic [CODE_W-1:0] EC_COPU   = 5'd11;
  localparam logic [CODE_W-1:0] EC_OVF    = 5'd12;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RESET = 2'd1,
    SRC_EXC   = 2'd2,
    SRC_IRQ   = 2'd3
  } src_e;

  typedef struct packed {
    logic              status_we;
    logic [DATA_W-1:0] status;
    logic              cause_we;
    logic [DATA_W-1:0] cause;
    logic              srs_we;
    logic [DATA_W-1:0] srsctl;
    logic              epc_we;
    logic [DATA_W-1:0] epc;
    logic              badva_we;
    logic [DATA_W-1:0] badva;
    logic              mmu_we;
    logic [DATA_W-1:0] entryhi;
    logic [VPN_W-1:0]  ctx_vpn;
  } commit_t;

  function automatic logic is_tlb_code(input logic [CODE_W-1:0] c);
    return (c == EC_TLBMOD) || (c == EC_TLBLD) || (c == EC_TLBST);
  endfunction

  function automatic logic has_bad_addr(input logic [CODE_W-1:0] c);
    return (c >= EC_TLBMOD) && (c <= EC_ADST);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic reset_req_i,
  input  logic exc_req_i,
  input  logic intr_req_i,
  output src_e src_o
);
  // Fixed priority: soft reset, then exception, then interrupt.
  always_comb begin
    if (reset_req_i)      src_o = SRC_RESET;
    else if (exc_req_i)   src_o = SRC_EXC;
    else if (intr_req_i)  src_o = SRC_IRQ;
    else                  src_o = SRC_NONE;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter logic [DATA_W-1:0]   BOOT_PC    = 32'hBFC0_0000,
  parameter logic [DATA_W-1:0]   BEV_OVF_PC = 32'hBFC0_0200,
  parameter logic [BASE_LSB-1:0] GEN_OFS    = 12'h180,
  parameter logic [BASE_LSB-1:0] IRQ_OFS    = 12'h200,
  parameter logic [BASE_LSB-1:0] REFILL_OFS = 12'h000
) (
  input  src_e              src_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              refill_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic              iv_i,
  input  logic [DATA_W-1:0] ebase_i,
  output logic [DATA_W-1:0] target_o
);
  logic [DATA_W-1:0]   base;
  logic [BASE_LSB-1:0] ofs;
  logic                refill_fast;
  logic                ovf_boot;

  assign base        = {ebase_i[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  // EXL is looked at as it was before this entry sets it.
  assign refill_fast = refill_i && ((code_i == EC_TLBLD) || (code_i == EC_TLBST))
                       && !status_i[ST_EXL];
  assign ovf_boot    = (code_i == EC_OVF) && status_i[ST_BEV];

  always_comb begin
    ofs = GEN_OFS;
    if (src_i == SRC_IRQ)
      ofs = iv_i ? IRQ_OFS : GEN_OFS;
    else if (refill_fast)
      ofs = REFILL_OFS;
  end

  always_comb begin
    unique case (src_i)
      SRC_RESET: target_o = BOOT_PC;
      SRC_EXC:   target_o = ovf_boot ? BEV_OVF_PC : (base | {{(DATA_W-BASE_LSB){1'b0}}, ofs});
      SRC_IRQ:   target_o = base | {{(DATA_W-BASE_LSB){1'b0}}, ofs};
      default:   target_o = BOOT_PC;
    endcase
  end
endmodule

// File: rtl/exc_reg_update.sv
module exc_reg_update
  import exc_entry_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  src_e              src_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              dslot_i,
  input  logic [DATA_W-1:0] bad_addr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [COP_W-1:0]  cop_id_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] cause_i,
  input  logic [DATA_W-1:0] srsctl_i,
  output commit_t           upd_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

  logic              entry;
  logic [CODE_W-1:0] eff_code;
  logic [COP_W-1:0]  ce_val;
  logic [DATA_W-1:0] st_new, ca_new, ss_new;

  assign entry    = (src_i == SRC_EXC) || (src_i == SRC_IRQ);
  assign eff_code = (src_i == SRC_IRQ) ? EC_IRQ : code_i;
  assign ce_val   = (eff_code == EC_COPU && src_i == SRC_EXC) ? cop_id_i : '0;

  always_comb begin
    st_new = status_i;
    if (src_i == SRC_RESET) st_new[ST_CU1] = 1'b1;
    else                    st_new[ST_EXL] = 1'b1;
  end

  always_comb begin
    ca_new = cause_i;
    ca_new[CA_CODE_LO +: CODE_W] = eff_code;
    ca_new[CA_CE_LO +: COP_W]    = ce_val;
    ca_new[CA_BD]                = dslot_i;
  end

  always_comb begin
    ss_new = srsctl_i;
    ss_new[SS_PREV_LO +: SET_W] = srsctl_i[SS_CUR_LO +: SET_W];
    ss_new[SS_CUR_LO  +: SET_W] = srsctl_i[SS_EXC_LO +: SET_W];
  end

  always_comb begin
    upd_o           = '0;
    upd_o.status_we = src_i != SRC_NONE;
    upd_o.status    = st_new;
    upd_o.cause_we  = entry;
    upd_o.cause     = ca_new;
    upd_o.srs_we    = entry && !status_i[ST_EXL] && !status_i[ST_BEV];
    upd_o.srsctl    = ss_new;
    upd_o.epc_we    = entry;
    upd_o.epc       = dslot_i ? (pc_i - STEP) : pc_i;
    upd_o.badva_we  = (src_i == SRC_EXC) && has_bad_addr(code_i);
    upd_o.badva     = bad_addr_i;
    upd_o.mmu_we    = (src_i == SRC_EXC) && is_tlb_code(code_i);
    upd_o.entryhi   = {bad_addr_i[DATA_W-1:VPN_LSB], {(VPN_LSB-ASID_W){1'b0}}, asid_i};
    upd_o.ctx_vpn   = bad_addr_i[DATA_W-1:VPN_LSB];
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter logic [31:0] BOOT_PC    = 32'hBFC0_0000,
  parameter logic [31:0] BEV_OVF_PC = 32'hBFC0_0200,
  parameter logic [11:0] GEN_OFS    = 12'h180,
  parameter logic [11:0] IRQ_OFS    = 12'h200,
  parameter int          INSN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_req_i,
  input  logic        exc_req_i,
  input  logic [4:0]  exc_code_i,
  input  logic        tlb_refill_i,
  input  logic        intr_req_i,
  input  logic [31:0] pc_i,
  input  logic        dslot_i,
  input  logic [31:0] bad_addr_i,
  input  logic [7:0]  asid_i,
  input  logic [1:0]  cop_id_i,
  input  logic [31:0] status_i,
  input  logic [31:0] cause_i,
  input  logic [31:0] srsctl_i,
  input  logic [31:0] ebase_i,
  output logic        redirect_o,
  output logic [31:0] fetch_pc_o,
  output logic        status_we_o,
  output logic [31:0] status_o,
  output logic        cause_we_o,
  output logic [31:0] cause_o,
  output logic        srs_we_o,
  output logic [31:0] srsctl_o,
  output logic        epc_we_o,
  output logic [31:0] epc_o,
  output logic        badva_we_o,
  output logic [31:0] badva_o,
  output logic        mmu_we_o,
  output logic [31:0] entryhi_o,
  output logic [18:0] ctx_vpn_o
);
  src_e              src;
  logic [DATA_W-1:0] target;
  commit_t           upd;
  commit_t           bundle_q;
  logic              redirect_q;
  logic [DATA_W-1:0] fetch_q;
  logic              take;

  exc_arbiter u_arb (
    .reset_req_i (reset_req_i),
    .exc_req_i   (exc_req_i),
    .intr_req_i  (intr_req_i),
    .src_o       (src)
  );

  exc_vector_sel #(
    .BOOT_PC    (BOOT_PC),
    .BEV_OVF_PC (BEV_OVF_PC),
    .GEN_OFS    (GEN_OFS),
    .IRQ_OFS    (IRQ_OFS)
  ) u_vec (
    .src_i    (src),
    .code_i   (exc_code_i),
    .refill_i (tlb_refill_i),
    .status_i (status_i),
    .iv_i     (cause_i[CA_IV]),
    .ebase_i  (ebase_i),
    .target_o (target)
  );

  exc_reg_update #(.INSN_BYTES(INSN_BYTES)) u_upd (
    .src_i      (src),
    .code_i     (exc_code_i),
    .pc_i       (pc_i),
    .dslot_i    (dslot_i),
    .bad_addr_i (bad_addr_i),
    .asid_i     (asid_i),
    .cop_id_i   (cop_id_i),
    .status_i   (status_i),
    .cause_i    (cause_i),
    .srsctl_i   (srsctl_i),
    .upd_o      (upd)
  );

  assign take = (src != SRC_NONE);

  // Strobes are registered every cycle; payload only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      bundle_q   <= '0;
      fetch_q    <= BOOT_PC;
    end else begin
      redirect_q         <= take;
      bundle_q.status_we <= upd.status_we;
      bundle_q.cause_we  <= upd.cause_we;
      bundle_q.srs_we    <= upd.srs_we;
      bundle_q.epc_we    <= upd.epc_we;
      bundle_q.badva_we  <= upd.badva_we;
      bundle_q.mmu_we    <= upd.mmu_we;
      if (take) begin
        fetch_q          <= target;
        bundle_q.status  <= upd.status;
        bundle_q.cause   <= upd.cause;
        bundle_q.srsctl  <= upd.srsctl;
        bundle_q.epc     <= upd.epc;
        bundle_q.badva   <= upd.badva;
        bundle_q.entryhi <= upd.entryhi;
        bundle_q.ctx_vpn <= upd.ctx_vpn;
      end
    end
  end

  assign redirect_o  = redirect_q;
  assign fetch_pc_o  = fetch_q;
  assign status_we_o = bundle_q.status_we;
  assign status_o    = bundle_q.status;
  assign cause_we_o  = bundle_q.cause_we;
  assign cause_o     = bundle_q.cause;
  assign srs_we_o    = bundle_q.srs_we;
  assign srsctl_o    = bundle_q.srsctl;
  assign epc_we_o    = bundle_q.epc_we;
  assign epc_o       = bundle_q.epc;
  assign badva_we_o  = bundle_q.badva_we;
  assign badva_o     = bundle_q.badva;
  assign mmu_we_o    = bundle_q.mmu_we;
  assign entryhi_o   = bundle_q.entryhi;
  assign ctx_vpn_o   = bundle_q.ctx_vpn;

  // R3: exception or interrupt entry always leaves EXL set in the new Status
  a_r3_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_req_i || intr_req_i) && !reset_req_i) |=> (status_we_o && status_o[1]));

  // R2: delay-slot entry backs EPC up one instruction and flags BD
  a_r2_dslot_epc: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_req_i || intr_req_i) && !reset_req_i && dslot_i)
      |=> (epc_o == $past(pc_i) - 32'd4) && cause_o[31]);

  // R4: no shadow-set write when EXL or BEV was already set
  a_r4_srs_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i[1] || status_i[22]) |=> !srs_we_o);

  // R12: a reset request redirects to the boot address and writes nothing but Status
  a_r12_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_i |=> (redirect_o && fetch_pc_o == BOOT_PC && !epc_we_o && !cause_we_o));

  // R13: with no request, nothing is written and the fetch address holds
  a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req_i && !exc_req_i && !intr_req_i)
      |=> (!redirect_o && !status_we_o && $stable(fetch_pc_o)));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reset_req, exc_req, refill, intr_req, dslot;
  logic [4:0]  code;
  logic [31:0] pc, bad_addr, status, cause, srsctl, ebase;
  logic [7:0]  asid;
  logic [1:0]  cop_id;
  logic        redirect, status_we, cause_we, srs_we, epc_we, badva_we, mmu_we;
  logic [31:0] fetch_pc, status_n, cause_n, srsctl_n, epc_n, badva_n, entryhi_n;
  logic [18:0] ctx_vpn;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reset_req_i(reset_req), .exc_req_i(exc_req),
    .exc_code_i(code), .tlb_refill_i(refill), .intr_req_i(intr_req), .pc_i(pc),
    .dslot_i(dslot), .bad_addr_i(bad_addr), .asid_i(asid), .cop_id_i(cop_id),
    .status_i(status), .cause_i(cause), .srsctl_i(srsctl), .ebase_i(ebase),
    .redirect_o(redirect), .fetch_pc_o(fetch_pc), .status_we_o(status_we),
    .status_o(status_n), .cause_we_o(cause_we), .cause_o(cause_n),
    .srs_we_o(srs_we), .srsctl_o(srsctl_n), .epc_we_o(epc_we), .epc_o(epc_n),
    .badva_we_o(badva_we), .badva_o(badva_n), .mmu_we_o(mmu_we),
    .entryhi_o(entryhi_n), .ctx_vpn_o(ctx_vpn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Cause as the requirements describe it: code in [6:2], CE in [29:28], BD in 31.
  function automatic logic [31:0] mk_cause(input logic [31:0] c, input logic [4:0] k,
                                           input logic [1:0] ce, input logic bd);
    logic [31:0] r = c;
    r[6:2] = k; r[29:28] = ce; r[31] = bd;
    return r;
  endfunction

  task automatic idle_inputs();
    reset_req = 0; exc_req = 0; intr_req = 0; refill = 0; dslot = 0;
  endtask

  // Drive at a falling edge, let one rising edge accept, sample at the next falling edge.
  task automatic fire();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R12 boot fetch", fetch_pc, 32'hBFC00000);
    chk("R12 no strobes", {26'd0, redirect, status_we, cause_we, srs_we, epc_we, badva_we}, 32'd0);
  endtask

  task automatic t_syscall();
    status = 32'h0000_0010; cause = 32'h3080_0000; srsctl = 32'h0000_5002;
    ebase = 32'h8000_0000; pc = 32'h0040_0100; bad_addr = 32'h1234_5678;
    exc_req = 1; code = 5'd8;
    fire();
    chk("R13 redirect", {31'd0, redirect}, 32'd1);
    chk("R1 cause code / R9 CE cleared", cause_n, mk_cause(32'h3080_0000, 5'd8, 2'd0, 1'b0));
    chk("R2 epc no slot", epc_n, 32'h0040_0100);
    chk("R3 exl set", status_n, 32'h0000_0012);
    chk("R4 srs swap we", {31'd0, srs_we}, 32'd1);
    chk("R4 srs value", srsctl_n, 32'h0000_5085);
    chk("R5 general vector", fetch_pc, 32'h8000_0180);
    chk("R10 no badva", {31'd0, badva_we}, 32'd0);
    chk("R11 no mmu", {31'd0, mmu_we}, 32'd0);
    idle_inputs();
    fire();
    chk("R13 pulse ends", {30'd0, redirect, status_we}, 32'd0);
    chk("R13 fetch holds", fetch_pc, 32'h8000_0180);
  endtask

  task automatic t_dslot();
    status = 32'h0000_0002; cause = 32'h0; pc = 32'h0000_1000;
    exc_req = 1; code = 5'd9; dslot = 1;
    fire();
    chk("R2 epc in slot", epc_n, 32'h0000_0FFC);
    chk("R2 bd set", {31'd0, cause_n[31]}, 32'd1);
    chk("R3 exl kept", status_n, 32'h0000_0002);
    chk("R4 srs held on exl", {31'd0, srs_we}, 32'd0);
    idle_inputs();
  endtask

  task automatic t_refill();
    ebase = 32'h8001_2000; bad_addr = 32'hABCD_E123; asid = 8'h5A;
    status = 32'h0; exc_req = 1; refill = 1; code = 5'd2;
    fire();
    chk("R6 refill exl0", fetch_pc, 32'h8001_2000);
    chk("R10 badva", badva_n, 32'hABCD_E123);
    chk("R11 entryhi", entryhi_n, 32'hABCD_E05A);
    chk("R11 ctx vpn", {13'd0, ctx_vpn}, {13'd0, 19'h55E6F});
    chk("R11 mmu we", {30'd0, mmu_we, badva_we}, 32'd3);
    status = 32'h0000_0002; code = 5'd3;
    fire();
    chk("R6 refill exl1", fetch_pc, 32'h8001_2180);
    refill = 0; status = 32'h0; code = 5'd3;
    fire();
    chk("R6 non-refill tlb", fetch_pc, 32'h8001_2180);
    idle_inputs();
  endtask

  task automatic t_overflow();
    ebase = 32'h8000_0000; status = 32'h0040_0000; exc_req = 1; code = 5'd12;
    fire();
    chk("R7 ovf bev1", fetch_pc, 32'hBFC0_0200);
    chk("R4 srs held on bev", {31'd0, srs_we}, 32'd0);
    status = 32'h0;
    fire();
    chk("R7 ovf bev0", fetch_pc, 32'h8000_0180);
    idle_inputs();
  endtask

  task automatic t_irq();
    ebase = 32'h9000_0000; status = 32'h0; cause = 32'h0080_0024; intr_req = 1;
    fire();
    chk("R8 iv1 vector", fetch_pc, 32'h9000_0200);
    chk("R1 irq code 0", cause_n, mk_cause(32'h0080_0024, 5'd0, 2'd0, 1'b0));
    chk("R10 irq no badva", {31'd0, badva_we}, 32'd0);
    cause = 32'h0;
    fire();
    chk("R8 iv0 vector", fetch_pc, 32'h9000_0180);
    idle_inputs();
  endtask

  task automatic t_copu();
    cause = 32'h0; cop_id = 2'd2; exc_req = 1; code = 5'd11;
    fire();
    chk("R9 CE loaded", {30'd0, cause_n[29:28]}, 32'd2);
    code = 5'd4; bad_addr = 32'h0000_0003;
    fire();
    chk("R9 CE clear other", {30'd0, cause_n[29:28]}, 32'd0);
    chk("R10 adel badva", {30'd0, badva_we, mmu_we}, 32'd2);
    idle_inputs();
  endtask

  task automatic t_priority();
    ebase = 32'h8000_0000; status = 32'h0000_0004; cause = 32'h0;
    reset_req = 1; exc_req = 1; code = 5'd4;
    fire();
    chk("R12 reset wins", fetch_pc, 32'hBFC0_0000);
    chk("R12 cu1 set", status_n, 32'h2000_0004);
    chk("R12 only status", {26'd0, status_we, cause_we, srs_we, epc_we, badva_we, mmu_we}, 32'h20);
    reset_req = 0; intr_req = 1; status = 32'h0; code = 5'd5;
    fire();
    chk("R13 exc beats irq code", {27'd0, cause_n[6:2]}, 32'd5);
    chk("R13 exc beats irq badva", {31'd0, badva_we}, 32'd1);
    idle_inputs();
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    code = 0; pc = 0; bad_addr = 0; asid = 0; cop_id = 0;
    status = 0; cause = 0; srsctl = 0; ebase = 32'h8000_0000;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_syscall();
    t_dslot();
    t_refill();
    t_overflow();
    t_irq();
    t_copu();
    t_priority();
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule